// File: doc/BRIEF.md
# I2C Bus Host Controller

This block is the host side of a two-wire serial bus. It opens a transfer with a Start condition and sends a byte that holds a 7-bit client address and a direction bit. It then writes or reads data one byte at a time, and it closes the bus with a Stop condition. A new Start command issued while the block holds the bus becomes a repeated Start. This lets one combined message mix writes and reads, to one client or to several, without releasing the bus.

Both wires are open-drain. The block never drives a one. It asserts a drive-low enable to put a zero on a wire, and it releases the wire so that the pull-up returns it high. A quarter-bit divider sets the bus timing, with four quarters to every bit. SDA passes through a two-stage synchronizer and is sampled at the middle of each SCL high time. The block accepts one command whenever it is idle. It returns a response pulse after every byte, carrying the byte seen on the bus and whether SDA was low in the ninth clock. If a client does not acknowledge an address or a written byte, the block raises an error. While the error is set it drops write and read commands.

Top module: `i2c_host`

## Requirements
- R1: After reset both drive-low enables are 0, cmd_ready is 1 and nack_err is 0.
- R2: A Start command (cmd_op 0) with the bus free produces a falling SDA edge while SCL is high, then sends cmd_data as the address byte: the 7-bit address in bits 7..1 and the direction bit in bit 0 (1 = read, 0 = write).
- R3: A Stop command (cmd_op 3) while the bus is held produces a rising SDA edge while SCL is high, and afterwards leaves both lines released.
- R4: SDA changes while SCL is high only for Start, repeated Start and Stop conditions, so the number of such edges on the bus equals the number of conditions commanded.
- R5: Address and write bytes (cmd_op 1) appear on SDA most significant bit first, one bit per SCL high pulse.
- R6: After every byte, rsp_valid pulses for one cycle, and rsp_acked is 1 exactly when SDA was low during the ninth SCL pulse.
- R7: A read command (cmd_op 2) releases SDA for eight clocks and returns the client's byte in rsp_data, first received bit in bit 7.
- R8: On a read, the host holds SDA low in the ninth clock when cmd_nack is 0 and releases it when cmd_nack is 1.
- R9: A Start command while the bus is held produces a repeated Start with no Stop before it.
- R10: An address or write byte that is not acknowledged sets nack_err. While nack_err is set, write and read commands are consumed with no SCL activity and no response. A Start or Stop command clears nack_err.
- R11: Each SCL high pulse of a data bit lasts 2*(quarter_div+1) clock cycles. quarter_div must be at least 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quarter_div | input | DIV_W | Clock cycles per quarter bit, minus one |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data | input | DATA_W | Address byte for start, data byte for write |
| cmd_nack | input | 1 | For read: 1 releases SDA in the ninth clock |
| rsp_valid | output | 1 | One-cycle pulse after each byte |
| rsp_data | output | DATA_W | Byte as seen on the bus |
| rsp_acked | output | 1 | SDA was low in the ninth clock |
| nack_err | output | 1 | Address or write byte was not acknowledged |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA level |

## Verification
A client model on the resolved bus decodes conditions and bits, acknowledges its own address and supplies read data. The bench drives it with random data bytes through single-write and single-read messages. A mismatch on those messages separates bit-order and shift errors from faults in the conditions. Combined messages that use a repeated Start separate the repeated-Start path from Stop followed by a new Start. Unmatched addresses and refused data bytes exercise the error path, which is checked by counting SCL edges while the dropped commands are issued. The high time of the clock pulses is measured under a randomly chosen quarter divider, and this isolates faults in the timing path.

// File: rtl/i2c_host_pkg.sv
// Shared types for the bus host: command codes and bit-level symbol kinds.
package i2c_host_pkg;

    // Command codes on cmd_op.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } cmd_op_t;

    // Bus symbols, each four quarter-bits long.
    typedef enum logic [1:0] {
        SYM_BIT     = 2'd0,
        SYM_START   = 2'd1,
        SYM_RESTART = 2'd2,
        SYM_STOP    = 2'd3
    } sym_t;

endpackage

// File: rtl/i2c_quarter_tick.sv
// Quarter-bit timer. While run is high it pulses tick once every
// quarter_div+1 cycles. It restarts from zero whenever run is low.
// Assumes quarter_div is held steady while run is high.
module i2c_quarter_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] quarter_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == quarter_div);

    // Count cycles inside the current quarter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bit_phy.sv
// Bit-level line driver. It plays one symbol (data bit, Start, repeated
// Start, Stop) over four quarters. Both lines are open-drain drive-low
// enables. SDA is synchronized and sampled at the middle of SCL high.
// Assumes symbols are only offered while sym_busy is low, and that
// quarter_div is at least 3 so that the synchronizer settles in time.
module i2c_bit_phy
    import i2c_host_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] quarter_div,
    input  logic             sym_valid,
    input  sym_t             sym_kind,
    input  logic             sym_bit,
    output logic             sym_busy,
    output logic             sym_done,
    output logic             rx_bit,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low
);

    localparam int QUARTERS = 4;
    localparam int Q_W      = $clog2(QUARTERS);
    localparam logic [Q_W-1:0] Q_LAST   = Q_W'(QUARTERS - 1);
    localparam logic [Q_W-1:0] Q_SAMPLE = Q_W'(1);

    logic           run_q;
    logic [Q_W-1:0] q_q;
    sym_t           kind_q;
    logic           bit_q;
    logic           scl_low_q, sda_low_q;
    logic           sda_s1, sda_s2;
    logic           tick;

    // Drive-low level of SCL for a symbol kind in a given quarter.
    function automatic logic scl_low_at(sym_t k, logic [Q_W-1:0] q);
        case (k)
            SYM_BIT:     return (q == 0) || (q == Q_LAST);
            SYM_START:   return (q == Q_LAST);
            SYM_RESTART: return (q == 0) || (q == Q_LAST);
            default:     return (q == 0);
        endcase
    endfunction

    // Drive-low level of SDA for a symbol kind in a given quarter.
    function automatic logic sda_low_at(sym_t k, logic [Q_W-1:0] q, logic b);
        case (k)
            SYM_BIT:     return !b;
            SYM_START,
            SYM_RESTART: return (q >= 2);
            default:     return (q < 2);
        endcase
    endfunction

    i2c_quarter_tick #(.DIV_W(DIV_W)) i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .quarter_div(quarter_div),
        .tick       (tick)
    );

    assign sym_busy      = run_q;
    assign scl_drive_low = scl_low_q;
    assign sda_drive_low = sda_low_q;

    // Two-stage synchronizer on the SDA input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_s1 <= 1'b1;
            sda_s2 <= 1'b1;
        end else begin
            sda_s1 <= sda_in;
            sda_s2 <= sda_s1;
        end
    end

    // Step through the quarters of a symbol and update the line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            q_q       <= '0;
            kind_q    <= SYM_BIT;
            bit_q     <= 1'b1;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
            rx_bit    <= 1'b1;
            sym_done  <= 1'b0;
        end else begin
            sym_done <= 1'b0;
            if (!run_q && sym_valid) begin
                run_q     <= 1'b1;
                q_q       <= '0;
                kind_q    <= sym_kind;
                bit_q     <= sym_bit;
                scl_low_q <= scl_low_at(sym_kind, '0);
                sda_low_q <= sda_low_at(sym_kind, '0, sym_bit);
            end else if (tick) begin
                if (q_q == Q_SAMPLE && kind_q == SYM_BIT) begin
                    rx_bit <= sda_s2;
                end
                if (q_q == Q_LAST) begin
                    run_q    <= 1'b0;
                    sym_done <= 1'b1;
                end else begin
                    q_q       <= q_q + 1'b1;
                    scl_low_q <= scl_low_at(kind_q, q_q + 1'b1);
                    sda_low_q <= sda_low_at(kind_q, q_q + 1'b1, bit_q);
                end
            end
        end
    end

    // R4: a data bit never moves SDA while SCL stays released.
    a_r4_data_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && kind_q == SYM_BIT && !scl_low_q && $past(!scl_low_q))
        |-> $stable(sda_low_q));

    // R2: the falling SDA edge of a Start happens with SCL released.
    a_r2_start_edge_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (kind_q == SYM_START || kind_q == SYM_RESTART) && $rose(sda_low_q))
        |-> !scl_low_q);

    // R3: the rising SDA edge of a Stop happens with SCL released.
    a_r3_stop_edge_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && kind_q == SYM_STOP && $fell(sda_low_q)) |-> !scl_low_q);

endmodule

// File: rtl/i2c_host.sv
// Byte-level host sequencer. It takes start/write/read/stop commands,
// turns each into bus symbols, and reports every byte together with its
// ninth-clock acknowledge level. Assumes cmd_* is held steady while
// cmd_valid is high, and that quarter_div is at least 3.
module i2c_host
    import i2c_host_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  quarter_div,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_nack,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_acked,
    output logic              nack_err,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_in
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

    typedef enum logic [1:0] {S_IDLE, S_COND, S_BITS} seq_t;

    seq_t              state_q;
    sym_t              cond_q;
    logic              owned_q, inflight_q, is_read_q, check_ack_q, host_nack_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              sym_valid, sym_bit, phy_busy, sym_done, rx_bit;
    sym_t              sym_kind;
    cmd_op_t           op;

    assign op        = cmd_op_t'(cmd_op);
    assign cmd_ready = (state_q == S_IDLE);
    assign rsp_data  = shreg_q;
    assign sym_valid = (state_q != S_IDLE) && !inflight_q;
    assign sym_kind  = (state_q == S_COND) ? cond_q : SYM_BIT;

    // Choose the bit level to put on SDA for the current slot.
    always_comb begin
        if (bit_cnt_q == ACK_SLOT) begin
            sym_bit = is_read_q ? host_nack_q : 1'b1;
        end else begin
            sym_bit = is_read_q ? 1'b1 : shreg_q[DATA_W-1];
        end
    end

    i2c_bit_phy #(.DIV_W(DIV_W)) i_phy (
        .clk          (clk),
        .rst_n        (rst_n),
        .quarter_div  (quarter_div),
        .sym_valid    (sym_valid),
        .sym_kind     (sym_kind),
        .sym_bit      (sym_bit),
        .sym_busy     (phy_busy),
        .sym_done     (sym_done),
        .rx_bit       (rx_bit),
        .sda_in       (sda_in),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low)
    );

    // Accept commands, sequence the symbols of a byte, and report results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            cond_q      <= SYM_START;
            owned_q     <= 1'b0;
            inflight_q  <= 1'b0;
            is_read_q   <= 1'b0;
            check_ack_q <= 1'b0;
            host_nack_q <= 1'b1;
            shreg_q     <= '0;
            bit_cnt_q   <= '0;
            rsp_valid   <= 1'b0;
            rsp_acked   <= 1'b0;
            nack_err    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (sym_valid && !phy_busy) begin
                inflight_q <= 1'b1;
            end
            if (sym_done) begin
                inflight_q <= 1'b0;
            end
            case (state_q)
                S_IDLE: if (cmd_valid) begin
                    bit_cnt_q <= '0;
                    case (op)
                        OP_START: begin
                            state_q     <= S_COND;
                            cond_q      <= owned_q ? SYM_RESTART : SYM_START;
                            shreg_q     <= cmd_data;
                            is_read_q   <= 1'b0;
                            check_ack_q <= 1'b1;
                            nack_err    <= 1'b0;
                        end
                        OP_STOP: if (owned_q) begin
                            state_q  <= S_COND;
                            cond_q   <= SYM_STOP;
                            nack_err <= 1'b0;
                        end
                        default: if (owned_q && !nack_err) begin
                            state_q     <= S_BITS;
                            shreg_q     <= cmd_data;
                            is_read_q   <= (op == OP_READ);
                            check_ack_q <= (op == OP_WRITE);
                            host_nack_q <= cmd_nack;
                        end
                    endcase
                end
                S_COND: if (sym_done) begin
                    owned_q <= (cond_q != SYM_STOP);
                    state_q <= (cond_q == SYM_STOP) ? S_IDLE : S_BITS;
                end
                default: if (sym_done) begin
                    if (bit_cnt_q == ACK_SLOT) begin
                        state_q   <= S_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_acked <= !rx_bit;
                        if (check_ack_q && rx_bit) begin
                            nack_err <= 1'b1;
                        end
                    end else begin
                        shreg_q   <= {shreg_q[DATA_W-2:0], rx_bit};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R10: with the error flag set, a write or read leaves the block idle.
    a_r10_err_drops_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && nack_err && (op == OP_WRITE || op == OP_READ))
        |=> (state_q == S_IDLE));

    // R1: a command is only offered while the line driver is idle.
    a_r1_ready_only_phy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !phy_busy);

endmodule

// File: tb/test_i2c_host.sv
`timescale 1ns/1ps
// Bench: a behavioural client on the resolved open-drain bus, directed
// corner cases and random messages with a fixed seed.
module test_i2c_host;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] quarter_div = 8'd3;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_nack = 1'b0;
    logic       rsp_valid, rsp_acked, nack_err;
    logic [7:0] rsp_data;
    logic       scl_drive_low, sda_drive_low;
    logic       cl_pull = 1'b0;
    logic       scl_bus, sda_bus;

    assign scl_bus = !scl_drive_low;
    assign sda_bus = !(sda_drive_low || cl_pull);

    always #2 clk = !clk;

    i2c_host i_i2c_host (
        .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_acked(rsp_acked), .nack_err(nack_err),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_bus)
    );

    int tests = 0, fails = 0;
    int starts = 0, stops = 0, exp_starts = 0, exp_stops = 0;
    int scl_falls = 0, rsp_cnt = 0, hi_cnt = 0, last_hi = 0;
    int bitn = 0, didx = 0;
    logic is_addr = 1'b0, active = 1'b0, reading = 1'b0, ack_seen = 1'b0;
    logic [7:0] rx = 8'd0, addr_byte = 8'd0, wr_byte = 8'd0, got_data = 8'd0;
    logic got_ack = 1'b0;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic [6:0] cl_addr = 7'h2A;
    logic cl_ack_data = 1'b1;
    logic [7:0] cl_tx = 8'd0;

    // Expected address byte: 7-bit address above the direction bit.
    function automatic logic [7:0] addr_of(logic [6:0] a, logic rd);
        return {a, rd};
    endfunction

    // Expected SCL high time of one data bit.
    function automatic int high_len(logic [7:0] d);
        return 2 * (int'(d) + 1);
    endfunction

    task automatic check_eq(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(logic [1:0] op, logic [7:0] d, logic nk);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_data = d; cmd_nack = nk; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        #1;
    endtask

    // Client model and bus monitor.
    always @(negedge clk) begin
        if (rsp_valid) begin
            got_data = rsp_data; got_ack = rsp_acked; rsp_cnt++;
        end
        if (p_scl && scl_bus && p_sda && !sda_bus) begin
            starts++; bitn = 0; didx = 0; is_addr = 1'b1; active = 1'b0; reading = 1'b0;
        end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
            stops++; bitn = 0; didx = 0; is_addr = 1'b0; active = 1'b0;
        end else if (!p_scl && scl_bus) begin
            hi_cnt = 0;
            if (bitn < 8) rx = {rx[6:0], sda_bus};
            else ack_seen = !sda_bus;
            bitn++;
        end else if (p_scl && !scl_bus) begin
            scl_falls++;
            last_hi = hi_cnt;
            if (bitn == 9) begin
                if (is_addr) begin
                    addr_byte = rx; active = (rx[7:1] == cl_addr);
                    reading = rx[0]; is_addr = 1'b0;
                end else if (!reading) begin
                    wr_byte = rx;
                end else if (!ack_seen) begin
                    active = 1'b0;
                end
                bitn = 0;
            end
            didx = bitn;
        end
        if (scl_bus) hi_cnt++;
        p_scl = scl_bus; p_sda = sda_bus;
        if (didx == 8)
            cl_pull = is_addr ? (rx[7:1] == cl_addr) : (active && !reading && cl_ack_data);
        else if (!is_addr && active && reading && didx < 8)
            cl_pull = !cl_tx[7 - didx];
        else
            cl_pull = 1'b0;
    end

    task automatic write_msg(int n);
        send(2'd0, addr_of(cl_addr, 1'b0), 1'b0); exp_starts++;
        check_eq("R2 start seen", starts, exp_starts);
        check_eq("R2 address byte", addr_byte, addr_of(cl_addr, 1'b0));
        check_eq("R6 address acked", got_ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            send(2'd1, d, 1'b0);
            check_eq("R5 write byte on bus", wr_byte, d);
            check_eq("R6 write response data", got_data, d);
            check_eq("R6 write acked", got_ack, 1);
            check_eq("R11 SCL high time", last_hi, high_len(quarter_div));
        end
    endtask

    task automatic read_bytes(int n);
        for (int i = 0; i < n; i++) begin
            logic nk;
            nk = (i == n - 1);
            cl_tx = 8'($urandom);
            send(2'd2, 8'd0, nk);
            check_eq("R7 read data", got_data, cl_tx);
            check_eq("R8 host ack level", ack_seen, !nk);
        end
    endtask

    task automatic stop_msg();
        send(2'd3, 8'd0, 1'b0); exp_stops++;
        check_eq("R3 stop seen", stops, exp_stops);
        check_eq("R3 lines released", scl_drive_low + sda_drive_low, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int f0, r0;
        void'($urandom(32'd4242));
        quarter_div = 8'(3 + $urandom_range(3));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 SCL released", scl_drive_low, 0);
        check_eq("R1 SDA released", sda_drive_low, 0);
        check_eq("R1 ready", cmd_ready, 1);
        check_eq("R1 no error", nack_err, 0);

        // Single write message.
        write_msg(3);
        stop_msg();

        // Single read message, last byte not acknowledged.
        send(2'd0, addr_of(cl_addr, 1'b1), 1'b0); exp_starts++;
        check_eq("R2 read address byte", addr_byte, addr_of(cl_addr, 1'b1));
        read_bytes(3);
        stop_msg();

        // Combined message with a repeated Start.
        write_msg(1);
        send(2'd0, addr_of(cl_addr, 1'b1), 1'b0); exp_starts++;
        check_eq("R9 repeated start seen", starts, exp_starts);
        check_eq("R9 no stop before restart", stops, exp_stops);
        read_bytes(2);
        stop_msg();

        // Address not acknowledged.
        send(2'd0, addr_of(7'h11, 1'b0), 1'b0); exp_starts++;
        check_eq("R6 address nack", got_ack, 0);
        check_eq("R10 error set", nack_err, 1);
        f0 = scl_falls; r0 = rsp_cnt;
        send(2'd1, 8'hA5, 1'b0);
        send(2'd2, 8'h00, 1'b0);
        repeat (40) @(negedge clk);
        check_eq("R10 no SCL activity", scl_falls, f0);
        check_eq("R10 no response", rsp_cnt, r0);
        check_eq("R10 error held", nack_err, 1);
        stop_msg();
        check_eq("R10 error cleared by stop", nack_err, 0);

        // Written data byte not acknowledged.
        send(2'd0, addr_of(cl_addr, 1'b0), 1'b0); exp_starts++;
        cl_ack_data = 1'b0;
        send(2'd1, 8'h3C, 1'b0);
        check_eq("R6 data nack", got_ack, 0);
        check_eq("R10 data nack error", nack_err, 1);
        cl_ack_data = 1'b1;
        send(2'd0, addr_of(cl_addr, 1'b0), 1'b0); exp_starts++;
        check_eq("R10 error cleared by start", nack_err, 0);
        stop_msg();

        // Random messages.
        for (int k = 0; k < 6; k++) begin
            int kind, n;
            kind = $urandom_range(2);
            n = 1 + $urandom_range(2);
            if (kind == 0) begin
                write_msg(n);
            end else if (kind == 1) begin
                send(2'd0, addr_of(cl_addr, 1'b1), 1'b0); exp_starts++;
                read_bytes(n);
            end else begin
                write_msg(1);
                send(2'd0, addr_of(cl_addr, 1'b1), 1'b0); exp_starts++;
                check_eq("R9 random restart", stops, exp_stops);
                read_bytes(n);
            end
            stop_msg();
        end

        repeat (10) @(negedge clk);
        check_eq("R4 SDA edges in SCL high as starts", starts, exp_starts);
        check_eq("R4 SDA edges in SCL high as stops", stops, exp_stops);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule